// File: doc/BRIEF.md
# I2S/TDM Transmit Serializer

This block turns parallel audio words into a serial audio stream. It generates its own bit clock from the system clock using an integer divider, and it drives a word-select (frame sync) line and a serial data line. It supports standard two-slot stereo framing and multi-slot time-division framing. Words come in through a valid/ready handshake, which normally sits on the read side of a sample FIFO.

The active settings are: slot count, slot length, data width, bit order, position of the data inside a slot, a per-slot enable mask, mono operation with a constant fill word, and a choice between stopping the clocks or running on when the input is empty. A host writes the settings to the staging ports and pulses an update strobe. The block moves them into use only when a new frame begins, so no frame mixes old and new settings. A sticky underrun flag records each time the block had to send a slot without a sample.

Top module: `i2s_tdm_tx`

## Requirements
- R1: After reset, and in any cycle after `run` has been low, `bclk`, `ws`, `sd` and `in_ready` are low. `underrun` is low after reset.
- R2: While running, each half period of `bclk` lasts `div_m1+1` clock cycles, so each bit cell lasts one `bclk` period. `sd` and `ws` change only while `bclk` is low, so they are stable across its rising edge.
- R3: With `cfg_tdm`=0 a frame has two slots, and each slot has `cfg_slot_bits_m1+1` bit cells. `ws` is low for slot 0 and high for slot 1, and it switches one bit cell before the first bit of a slot.
- R4: With `cfg_lsb_first`=1 a sample goes out starting at its bit 0. With 0 it goes out starting at bit `cfg_width_m1`.
- R5: A slot carries the low `cfg_width_m1+1` bits of its word. With `cfg_right_align`=0 they fill the first cells of the slot, and with 1 they fill the last cells. Every other cell of the slot is 0.
- R6: With `cfg_tdm`=1 a frame has `cfg_slots_m1+1` slots. `ws` is high only in the last bit cell of a frame, which is one cell before bit 0 of slot 0.
- R7: In TDM mode bit s of `cfg_slot_mask` enables slot s. A disabled slot sends all zeros and takes no word from the input.
- R8: With `cfg_tdm`=0 and `cfg_mono`=1, the slot whose number equals `cfg_mono_sel` carries input samples. The other slot carries `cfg_fill`, formatted like a sample. Only one word per frame is taken from the input.
- R9: With `cfg_halt`=1, when a slot needs a word and none is valid, `bclk` stays low and `ws` and `sd` hold their values until a word arrives. This does not set `underrun`.
- R10: With `cfg_halt`=0, a slot that needs a word when none is valid sends zeros and sets `underrun`. The flag stays set until `underrun_clr` is high. If a new underrun occurs in the same cycle as the clear, the flag stays set.
- R11: A pulse on `cfg_update` captures the staging ports. The captured settings take effect at the first bit of the next frame, or at once while `run` is low.
- R12: A word is taken in a cycle where `in_ready` and `in_valid` are both high. `in_ready` is high for one cycle at the start of each slot that needs a word. Words are used in slot order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables clocking; when low, outputs idle and the frame restarts |
| div_m1 | input | DIV_W | Half period of the bit clock in clock cycles, minus one |
| cfg_tdm | input | 1 | Staged: 1 selects multi-slot TDM framing |
| cfg_slots_m1 | input | SLOT_W | Staged: TDM slot count minus one |
| cfg_slot_bits_m1 | input | BIT_W | Staged: bit cells per slot minus one |
| cfg_width_m1 | input | BIT_W | Staged: data bits per slot minus one (not above slot bits) |
| cfg_lsb_first | input | 1 | Staged: 1 sends the LSB first |
| cfg_right_align | input | 1 | Staged: 1 places data at the end of the slot |
| cfg_mono | input | 1 | Staged: mono operation in two-slot mode |
| cfg_mono_sel | input | 1 | Staged: slot number that carries samples in mono |
| cfg_halt | input | 1 | Staged: 1 stops the clocks when the input is empty |
| cfg_slot_mask | input | MAX_SLOTS | Staged: per-slot enable in TDM mode |
| cfg_fill | input | DATA_W | Staged: constant word for the unused mono slot |
| cfg_update | input | 1 | Strobe that captures the staged settings |
| in_data | input | DATA_W | Sample word |
| in_valid | input | 1 | Sample word available |
| in_ready | output | 1 | Sample word taken this cycle when valid |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select / frame sync |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Sticky flag: a slot was sent without a sample |
| underrun_clr | input | 1 | Clears the underrun flag |

## Verification
The flag logic must handle a clear request and a fresh underrun in the same cycle. The bench sets up this collision by running with an empty input and the clock halt turned off. It watches for the cycle in which `in_ready` is high with no valid word, and raises `underrun_clr` for exactly that cycle. The flag must still be set one cycle later. After clocking is stopped, a clear with no competing event must take the flag low.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int MAX_SLOTS     = 8;
    localparam int MAX_SLOT_BITS = 32;
    localparam int DATA_W        = 32;
    localparam int SLOT_W        = $clog2(MAX_SLOTS);
    localparam int BIT_W         = $clog2(MAX_SLOT_BITS);
    localparam int DIDX_W        = $clog2(DATA_W);

    // Settings used by the serializer
    typedef struct packed {
        logic                  tdm;
        logic [SLOT_W-1:0]     slots_m1;
        logic [BIT_W-1:0]      slot_bits_m1;
        logic [BIT_W-1:0]      width_m1;
        logic                  lsb_first;
        logic                  right_align;
        logic                  mono;
        logic                  mono_sel;
        logic                  halt;
        logic [MAX_SLOTS-1:0]  mask;
        logic [DATA_W-1:0]     fill;
    } cfg_t;

    // Position of a bit cell inside a frame
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
    } pos_t;

    // Where the word for a slot comes from
    typedef enum logic [1:0] {
        SRC_ZERO  = 2'd0,
        SRC_FILL  = 2'd1,
        SRC_INPUT = 2'd2
    } src_e;

    function automatic logic [SLOT_W-1:0] last_slot(cfg_t c);
        return c.tdm ? c.slots_m1 : SLOT_W'(1);
    endfunction

    function automatic pos_t pos_advance(pos_t p, cfg_t c);
        pos_t n;
        n = p;
        if (p.bitn == c.slot_bits_m1) begin
            n.bitn = '0;
            n.slot = (p.slot == last_slot(c)) ? '0 : p.slot + SLOT_W'(1);
        end else begin
            n.bitn = p.bitn + BIT_W'(1);
        end
        return n;
    endfunction

    function automatic src_e slot_source(logic [SLOT_W-1:0] s, cfg_t c);
        if (c.tdm)
            return c.mask[s] ? SRC_INPUT : SRC_ZERO;
        if (c.mono && (s[0] != c.mono_sel))
            return SRC_FILL;
        return SRC_INPUT;
    endfunction

    // Word-select level for the cell at p: it looks one cell ahead
    function automatic logic frame_sync(pos_t p, cfg_t c);
        pos_t q;
        q = pos_advance(p, c);
        if (c.tdm)
            return (q == '0);
        return (q.slot == SLOT_W'(1));
    endfunction

    // Serial bit for cell b of a slot holding word w
    function automatic logic pick_bit(logic [DATA_W-1:0] w, logic [BIT_W-1:0] b, cfg_t c);
        logic [BIT_W:0]    sb;
        logic [BIT_W:0]    dw;
        logic [BIT_W:0]    off;
        logic [BIT_W:0]    k;
        logic [BIT_W:0]    sel;
        logic [DIDX_W-1:0] idx;
        sb  = {1'b0, c.slot_bits_m1} + (BIT_W+1)'(1);
        dw  = {1'b0, c.width_m1} + (BIT_W+1)'(1);
        off = (c.right_align && (sb > dw)) ? (sb - dw) : '0;
        if ({1'b0, b} < off)
            return 1'b0;
        k = {1'b0, b} - off;
        if (k >= dw)
            return 1'b0;
        sel = c.lsb_first ? k : (dw - (BIT_W+1)'(1) - k);
        idx = DIDX_W'(sel);
        return w[idx];
    endfunction

endpackage

// File: rtl/i2s_tx_bclk_gen.sv
module i2s_tx_bclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_m1,
    input  logic             stall,
    output logic             bclk,
    output logic             shift_evt
);

    logic [DIV_W-1:0] cnt;
    logic             rise_next;
    logic             edge_evt;

    assign edge_evt  = run && (cnt == div_m1);
    assign shift_evt = edge_evt && !rise_next;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt       <= '0;
            bclk      <= 1'b0;
            rise_next <= 1'b0;
        end else begin
            cnt <= edge_evt ? '0 : cnt + DIV_W'(1);
            if (edge_evt) begin
                if (rise_next) begin
                    bclk      <= 1'b1;
                    rise_next <= 1'b0;
                end else begin
                    bclk <= 1'b0;
                    if (!stall)
                        rise_next <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2s_tx_cfg_stage.sv
module i2s_tx_cfg_stage
    import i2s_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic update,
    input  cfg_t staged,
    input  logic load,
    output cfg_t active,
    output cfg_t shadow,
    output logic pending
);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= '0;
            shadow  <= '0;
            pending <= 1'b0;
        end else begin
            if ((load || !run) && pending) begin
                active  <= shadow;
                pending <= 1'b0;
            end
            if (update) begin
                shadow  <= staged;
                pending <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2s_tx_slot_seq.sv
module i2s_tx_slot_seq
    import i2s_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              shift_evt,
    input  cfg_t              active,
    input  cfg_t              shadow,
    input  logic              pending,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              load,
    output logic              stall,
    output logic              miss,
    output logic              sd,
    output logic              ws
);

    pos_t              pos;
    pos_t              nxt;
    logic              started;
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] word_n;
    cfg_t              cu;
    src_e              src;
    logic              at_start;
    logic              new_slot;
    logic              need;

    always_comb begin
        nxt      = started ? pos_advance(pos, active) : '0;
        at_start = (nxt == '0);
        cu       = (at_start && pending) ? shadow : active;
        new_slot = (nxt.bitn == '0);
        src      = slot_source(nxt.slot, cu);
        need     = new_slot && (src == SRC_INPUT);
        stall    = need && !in_valid && cu.halt;
        in_ready = shift_evt && need;
        miss     = shift_evt && need && !in_valid && !cu.halt;
        load     = shift_evt && at_start && pending && !stall;
        word_n   = cur_word;
        if (new_slot) begin
            unique case (src)
                SRC_FILL:  word_n = cu.fill;
                SRC_INPUT: word_n = in_valid ? in_data : '0;
                default:   word_n = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos      <= '0;
            started  <= 1'b0;
            cur_word <= '0;
            sd       <= 1'b0;
            ws       <= 1'b0;
        end else if (shift_evt && !stall) begin
            pos      <= nxt;
            started  <= 1'b1;
            cur_word <= word_n;
            sd       <= pick_bit(word_n, nxt.bitn, cu);
            ws       <= frame_sync(nxt, cu);
        end
    end

endmodule

// File: rtl/i2s_tdm_tx.sv
module i2s_tdm_tx
    import i2s_tx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic [DIV_W-1:0]     div_m1,
    input  logic                 cfg_tdm,
    input  logic [SLOT_W-1:0]    cfg_slots_m1,
    input  logic [BIT_W-1:0]     cfg_slot_bits_m1,
    input  logic [BIT_W-1:0]     cfg_width_m1,
    input  logic                 cfg_lsb_first,
    input  logic                 cfg_right_align,
    input  logic                 cfg_mono,
    input  logic                 cfg_mono_sel,
    input  logic                 cfg_halt,
    input  logic [MAX_SLOTS-1:0] cfg_slot_mask,
    input  logic [DATA_W-1:0]    cfg_fill,
    input  logic                 cfg_update,
    input  logic [DATA_W-1:0]    in_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    output logic                 bclk,
    output logic                 ws,
    output logic                 sd,
    output logic                 underrun,
    input  logic                 underrun_clr
);

    cfg_t stg_cfg;
    cfg_t act_cfg;
    cfg_t shd_cfg;
    logic cfg_pending;
    logic cfg_load;
    logic shift_evt;
    logic stall;
    logic miss;

    always_comb begin
        stg_cfg.tdm          = cfg_tdm;
        stg_cfg.slots_m1     = cfg_slots_m1;
        stg_cfg.slot_bits_m1 = cfg_slot_bits_m1;
        stg_cfg.width_m1     = cfg_width_m1;
        stg_cfg.lsb_first    = cfg_lsb_first;
        stg_cfg.right_align  = cfg_right_align;
        stg_cfg.mono         = cfg_mono;
        stg_cfg.mono_sel     = cfg_mono_sel;
        stg_cfg.halt         = cfg_halt;
        stg_cfg.mask         = cfg_slot_mask;
        stg_cfg.fill         = cfg_fill;
    end

    i2s_tx_cfg_stage u_cfg (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .update  (cfg_update),
        .staged  (stg_cfg),
        .load    (cfg_load),
        .active  (act_cfg),
        .shadow  (shd_cfg),
        .pending (cfg_pending)
    );

    i2s_tx_bclk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .div_m1    (div_m1),
        .stall     (stall),
        .bclk      (bclk),
        .shift_evt (shift_evt)
    );

    i2s_tx_slot_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .shift_evt (shift_evt),
        .active    (act_cfg),
        .shadow    (shd_cfg),
        .pending   (cfg_pending),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .load      (cfg_load),
        .stall     (stall),
        .miss      (miss),
        .sd        (sd),
        .ws        (ws)
    );

    // A fresh miss outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            underrun <= 1'b0;
        else
            underrun <= (underrun && !underrun_clr) || miss;
    end

endmodule

// File: rtl/i2s_tx_checks.sv
module i2s_tx_checks
    import i2s_tx_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic run,
    input logic bclk,
    input logic ws,
    input logic sd,
    input logic in_ready,
    input logic in_valid,
    input logic underrun,
    input logic underrun_clr,
    input logic cfg_load,
    input cfg_t act_cfg
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!bclk && !ws && !sd && !in_ready));  // R1

    AST_SD_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$stable(sd)) |-> !bclk);  // R2

    AST_WS_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$stable(ws)) |-> !bclk);  // R3

    AST_FETCH_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> !bclk);  // R12

    AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> ($past(in_ready) && !$past(in_valid)));  // R10

    AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (underrun && !underrun_clr) |=> underrun);  // R10

    AST_CFG_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$stable(act_cfg)) |-> $past(cfg_load));  // R11

endmodule

bind i2s_tdm_tx i2s_tx_checks u_chk (
    .clk          (clk),
    .rst          (rst),
    .run          (run),
    .bclk         (bclk),
    .ws           (ws),
    .sd           (sd),
    .in_ready     (in_ready),
    .in_valid     (in_valid),
    .underrun     (underrun),
    .underrun_clr (underrun_clr),
    .cfg_load     (cfg_load),
    .act_cfg      (act_cfg)
);

// File: tb/sim_i2s_tdm_tx.sv
module sim_i2s_tdm_tx;
    import i2s_tx_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 run = 1'b0;
    logic [7:0]           div_m1 = 8'd1;
    logic                 cfg_tdm = 1'b0;
    logic [SLOT_W-1:0]    cfg_slots_m1 = '0;
    logic [BIT_W-1:0]     cfg_slot_bits_m1 = '0;
    logic [BIT_W-1:0]     cfg_width_m1 = '0;
    logic                 cfg_lsb_first = 1'b0;
    logic                 cfg_right_align = 1'b0;
    logic                 cfg_mono = 1'b0;
    logic                 cfg_mono_sel = 1'b0;
    logic                 cfg_halt = 1'b0;
    logic [MAX_SLOTS-1:0] cfg_slot_mask = '0;
    logic [DATA_W-1:0]    cfg_fill = '0;
    logic                 cfg_update = 1'b0;
    logic [DATA_W-1:0]    in_data = '0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic                 bclk;
    logic                 ws;
    logic                 sd;
    logic                 underrun;
    logic                 underrun_clr = 1'b0;

    always #5 clk = ~clk;

    i2s_tdm_tx u0 (
        .clk(clk), .rst(rst), .run(run), .div_m1(div_m1),
        .cfg_tdm(cfg_tdm), .cfg_slots_m1(cfg_slots_m1),
        .cfg_slot_bits_m1(cfg_slot_bits_m1), .cfg_width_m1(cfg_width_m1),
        .cfg_lsb_first(cfg_lsb_first), .cfg_right_align(cfg_right_align),
        .cfg_mono(cfg_mono), .cfg_mono_sel(cfg_mono_sel), .cfg_halt(cfg_halt),
        .cfg_slot_mask(cfg_slot_mask), .cfg_fill(cfg_fill), .cfg_update(cfg_update),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .bclk(bclk), .ws(ws), .sd(sd), .underrun(underrun),
        .underrun_clr(underrun_clr)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int cap_n  = 0;
    logic cap_sd [0:511];
    logic cap_ws [0:511];
    int   cap_cyc[0:511];
    logic prev_bclk = 1'b0;
    logic [31:0] feed [0:63];
    int feed_n  = 0;
    int feed_rd = 0;
    logic [31:0] exp_w [0:63];

    // Capture sd/ws at each rising bit-clock edge, seen between clock edges
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (bclk && !prev_bclk && cap_n < 512) begin
            cap_sd[cap_n]  = sd;
            cap_ws[cap_n]  = ws;
            cap_cyc[cap_n] = cyc;
            cap_n = cap_n + 1;
        end
        prev_bclk = bclk;
    end

    // Source of sample words
    always begin
        logic hs;
        @(negedge clk);
        hs = in_ready && in_valid;
        @(posedge clk);
        #1;
        if (hs) feed_rd = feed_rd + 1;
        in_valid = (feed_rd < feed_n);
        in_data  = (feed_rd < feed_n) ? feed[feed_rd] : '0;
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic set_cfg(bit tdm, int slm1, int sbm1, int wm1, bit lsb, bit right,
                           bit mono, bit msel, bit halt, logic [7:0] mask, logic [31:0] fill);
        @(negedge clk);
        cfg_tdm          = tdm;
        cfg_slots_m1     = SLOT_W'(slm1);
        cfg_slot_bits_m1 = BIT_W'(sbm1);
        cfg_width_m1     = BIT_W'(wm1);
        cfg_lsb_first    = lsb;
        cfg_right_align  = right;
        cfg_mono         = mono;
        cfg_mono_sel     = msel;
        cfg_halt         = halt;
        cfg_slot_mask    = mask;
        cfg_fill         = fill;
        cfg_update       = 1'b1;
        @(negedge clk);
        cfg_update       = 1'b0;
    endtask

    task automatic prepare();
        @(negedge clk);
        run = 1'b0;
        repeat (4) @(negedge clk);
        feed_n  = 0;
        feed_rd = 0;
        underrun_clr = 1'b1;
        @(negedge clk);
        underrun_clr = 1'b0;
        for (int i = 0; i < 64; i++) exp_w[i] = '0;
    endtask

    task automatic go();
        repeat (3) @(negedge clk);
        cap_n = 0;
        run = 1'b1;
    endtask

    task automatic wait_caps(int n);
        int t = 0;
        while (cap_n < n && t < 20000) begin
            @(negedge clk);
            t++;
        end
        run = 1'b0;
    endtask

    task automatic verify_stream(string tag, int f0, int nf, int nsl, int sb, int dw,
                                 bit lsb, bit right, bit tdm);
        int fr_len = nsl * sb;
        int bad_sd = 0;
        int bad_ws = 0;
        chk({tag, " capture count"}, (cap_n >= (f0 + nf) * fr_len), 1);
        for (int i = f0 * fr_len; i < (f0 + nf) * fr_len; i++) begin
            int j   = i % fr_len;
            int fr  = i / fr_len;
            int sl  = j / sb;
            int b   = j % sb;
            int off = (right && sb > dw) ? sb - dw : 0;
            int k   = b - off;
            logic [31:0] w = exp_w[fr * nsl + sl];
            logic e_sd;
            logic e_ws;
            e_sd = (b < off || k >= dw) ? 1'b0 : w[lsb ? k : dw - 1 - k];
            e_ws = tdm ? (j == fr_len - 1) : (((j + 1) % fr_len) >= sb);
            if (cap_sd[i] !== e_sd) bad_sd++;
            if (cap_ws[i] !== e_ws) bad_ws++;
        end
        chk({tag, " sd mismatches"}, bad_sd, 0);
        chk({tag, " ws mismatches"}, bad_ws, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 bclk after reset", bclk, 0);
        chk("R1 ws after reset", ws, 0);
        chk("R1 sd after reset", sd, 0);
        chk("R1 in_ready after reset", in_ready, 0);
        chk("R1 underrun after reset", underrun, 0);
    endtask

    task automatic t_i2s_msb_left();
        prepare();
        div_m1 = 8'd1;
        set_cfg(0, 0, 15, 15, 0, 0, 0, 0, 0, 8'h00, 32'h0);
        feed[0] = 32'h0001_A5C3; feed[1] = 32'h0000_8001;
        feed[2] = 32'h0000_7E18; feed[3] = 32'hFFFF_0F0F;
        for (int i = 0; i < 4; i++) exp_w[i] = feed[i];
        feed_n = 4;
        go();
        wait_caps(64);
        verify_stream("R3 R4 i2s msb-first", 0, 2, 2, 16, 16, 0, 0, 0);
        chk("R2 bit period div1", cap_cyc[1] - cap_cyc[0], 4);
        chk("R12 words taken", feed_rd, 4);
        repeat (3) @(negedge clk);
        chk("R1 bclk idle after stop", bclk, 0);
        chk("R1 ws idle after stop", ws, 0);
    endtask

    task automatic t_i2s_lsb_right();
        prepare();
        div_m1 = 8'd2;
        set_cfg(0, 0, 23, 11, 1, 1, 0, 0, 0, 8'h00, 32'h0);
        feed[0] = 32'h00FF_FABC; feed[1] = 32'h0000_0123;
        feed[2] = 32'h0000_0801; feed[3] = 32'h0000_0F5A;
        for (int i = 0; i < 4; i++) exp_w[i] = feed[i];
        feed_n = 4;
        go();
        wait_caps(96);
        verify_stream("R5 R4 lsb-first right-aligned", 0, 2, 2, 24, 12, 1, 1, 0);
        chk("R2 bit period div2", cap_cyc[1] - cap_cyc[0], 6);
        div_m1 = 8'd1;
    endtask

    task automatic t_mono();
        prepare();
        set_cfg(0, 0, 15, 15, 0, 0, 1, 1, 0, 8'h00, 32'h0000_5A3C);
        feed[0] = 32'h0000_C001; feed[1] = 32'h0000_1234;
        exp_w[0] = 32'h5A3C; exp_w[1] = feed[0];
        exp_w[2] = 32'h5A3C; exp_w[3] = feed[1];
        feed_n = 2;
        go();
        wait_caps(64);
        verify_stream("R8 mono fill", 0, 2, 2, 16, 16, 0, 0, 0);
        chk("R8 one word per frame", feed_rd, 2);
    endtask

    task automatic t_tdm_mask();
        prepare();
        set_cfg(1, 3, 7, 7, 0, 0, 0, 0, 0, 8'b0000_1011, 32'h0);
        feed[0] = 32'hA1; feed[1] = 32'h3C; feed[2] = 32'hF0;
        feed[3] = 32'h5E; feed[4] = 32'h81; feed[5] = 32'h0F;
        exp_w[0] = 32'hA1; exp_w[1] = 32'h3C; exp_w[2] = 0; exp_w[3] = 32'hF0;
        exp_w[4] = 32'h5E; exp_w[5] = 32'h81; exp_w[6] = 0; exp_w[7] = 32'h0F;
        feed_n = 6;
        go();
        wait_caps(64);
        verify_stream("R6 R7 tdm masked", 0, 2, 4, 8, 8, 0, 0, 1);
        chk("R7 masked slot takes no word", feed_rd, 6);
    endtask

    task automatic t_halt();
        prepare();
        set_cfg(0, 0, 7, 7, 0, 0, 0, 0, 1, 8'h00, 32'h0);
        go();
        repeat (40) @(negedge clk);
        chk("R9 no bit clock while empty", cap_n, 0);
        chk("R9 bclk held low", bclk, 0);
        chk("R9 no underrun under halt", underrun, 0);
        feed[0] = 32'h96; feed[1] = 32'h3B;
        exp_w[0] = 32'h96; exp_w[1] = 32'h3B;
        feed_n = 2;
        wait_caps(16);
        verify_stream("R9 resumes with data", 0, 1, 2, 8, 8, 0, 0, 0);
    endtask

    task automatic t_underrun();
        int t = 0;
        prepare();
        set_cfg(0, 0, 7, 7, 0, 0, 0, 0, 0, 8'h00, 32'h0);
        go();
        while (cap_n < 16 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        verify_stream("R10 zeros on underrun", 0, 1, 2, 8, 8, 0, 0, 0);
        chk("R10 flag set", underrun, 1);
        t = 0;
        while (!(in_ready && !in_valid) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        underrun_clr = 1'b1;
        @(negedge clk);
        underrun_clr = 1'b0;
        chk("R10 set wins over clear", underrun, 1);
        run = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 flag sticky", underrun, 1);
        underrun_clr = 1'b1;
        @(negedge clk);
        underrun_clr = 1'b0;
        chk("R10 flag cleared", underrun, 0);
    endtask

    task automatic t_cfg_update();
        int t = 0;
        prepare();
        set_cfg(0, 0, 15, 15, 0, 0, 0, 0, 0, 8'h00, 32'h0);
        feed[0] = 32'hB00C; feed[1] = 32'h4E21; feed[2] = 32'h0C3F; feed[3] = 32'h9001;
        for (int i = 0; i < 4; i++) exp_w[i] = feed[i];
        feed_n = 4;
        go();
        while (cap_n < 8 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        set_cfg(0, 0, 15, 15, 1, 0, 0, 0, 0, 8'h00, 32'h0);
        wait_caps(64);
        verify_stream("R11 old settings hold to frame end", 0, 1, 2, 16, 16, 0, 0, 0);
        verify_stream("R11 new settings from next frame", 1, 1, 2, 16, 16, 1, 0, 0);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_i2s_msb_left();
        t_i2s_lsb_right();
        t_mono();
        t_tdm_mask();
        t_halt();
        t_underrun();
        t_cfg_update();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule